// File: doc/BRIEF.md
# Calibrated 512-to-100 Tick Divider for a Real-Time Clock

The block sits between an oscillator prescaler and the fraction-of-seconds counter of a real-time clock. It takes a one-cycle enable that arrives at 512 Hz and turns it into a 100 Hz enable. In the normal case every window of 512 input enables yields exactly 100 output enables. The output enables are spread evenly across the window by a fractional accumulator. The block also counts output enables into seconds and seconds into minutes. It raises a one-cycle strobe at the end of each second and at the end of each minute.

The clock rate is trimmed through a 6-bit setting that is written and read over a plain port. Bits 4:0 hold a magnitude N and bit 5 holds the direction. With the direction bit at 1, the first N seconds of every minute are shortened to 511 input enables, so the clock runs fast by 1/512 s in each of those seconds. With the direction bit at 0, the first N seconds are lengthened to 513 input enables, which slows the clock. In that case the correction applies only in alternate minutes. The setting is taken up only when a second begins, so a window never changes while it is running.

A separate test-frequency output copies the uncorrected 512 Hz enable, delayed by one register, so the correction never shows on it.

Top module: `rtc_cal_divider`

## Requirements
- R1: Every second contains exactly OUT_PER_WIN (100) `tick_out` pulses. Each `tick_out` is high in the cycle after a cycle in which `tick_in` was high, and `sec_pulse` is high together with the 100th pulse of the second.
- R2: A second that is not corrected spans exactly IN_PER_WIN (512) `tick_in` pulses, counted up to and including the one that ends it.
- R3: When `cfg_wdata[5]` = 1 and the magnitude `cfg_wdata[4:0]` = N is not zero, seconds 0 to N-1 of every minute each span 511 `tick_in` pulses. Any second whose index is N or higher spans 512.
- R4: When bit 5 = 0 and N is not zero, seconds 0 to N-1 span 513 `tick_in` pulses, but only in minutes of even parity. The first minute after reset has even parity and the parity alternates after that. In minutes of odd parity every second spans 512.
- R5: A magnitude of 0 disables correction whatever the value of bit 5, and every second then spans 512 `tick_in` pulses.
- R6: `min_pulse` is high exactly in the cycle of the `sec_pulse` that ends second SEC_PER_MIN-1 of a minute. It is never high at any other time.
- R7: `cfg_rdata` shows the value last written. It shows that value from the cycle after the `cfg_wr` cycle, and it reads 0 after reset.
- R8: A write to the setting has no effect on the second in progress. It applies from the next second that begins.
- R9: `ftest_tick` is high exactly in the cycle after each `tick_in` cycle, whatever the correction setting.
- R10: A synchronous active-low reset does the following. It clears the setting, the accumulator, the tick and second counters and the minute parity. It drives every strobe low. The first second after reset spans 512 `tick_in` pulses and is second 0 of an even minute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | 1 | One-cycle enable at 512 Hz from the prescaler |
| cfg_wr | input | 1 | Write strobe for the correction setting |
| cfg_wdata | input | 6 | New setting: bit 5 direction (1 = fast), bits 4:0 magnitude |
| cfg_rdata | output | 6 | Current setting |
| tick_out | output | 1 | One-cycle enable at 100 Hz after correction |
| sec_pulse | output | 1 | One-cycle strobe with the last tick of each second |
| min_pulse | output | 1 | One-cycle strobe with the last second of each minute |
| ftest_tick | output | 1 | Uncorrected 512 Hz enable for frequency test |

## Verification
The assertions take for granted that `tick_in` is a single-cycle enable. They also assume that `cfg_wr` is never asserted while reset is active in the previous cycle. The bench keeps to both assumptions: it raises `tick_in` for one cycle, leaves one idle cycle after it, and writes the setting only during idle cycles after reset has been released. The bench shortens the minute to 8 seconds by a parameter, so that alternate-minute behaviour and magnitudes larger than a minute can be reached within the run. It measures each second by counting the input enables it has driven between strobes.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
// Package rtc_cal_pkg
// Holds the layout of the correction setting and the kinds of window that the
// divider can run. The bit positions are fixed because software writes them.
package rtc_cal_pkg;

    localparam int CAL_MAG_W = 5;
    localparam int CAL_CFG_W = CAL_MAG_W + 1;

    // Bit 5 is the direction, bits 4:0 are the magnitude.
    typedef struct packed {
        logic                 fast;
        logic [CAL_MAG_W-1:0] mag;
    } cal_cfg_t;

    // Kind of window used for one second.
    typedef enum logic [1:0] {
        WIN_PLAIN = 2'd0,
        WIN_SHORT = 2'd1,
        WIN_LONG  = 2'd2
    } win_kind_e;

endpackage

// File: rtl/rtc_cal_cfg_reg.sv
`timescale 1ns/1ps
// Module rtc_cal_cfg_reg
// Stores the 6-bit correction setting written over the plain port and returns
// it for read-back. Assumes that writes are single-cycle strobes. The stored
// value is passed on as a struct to the window selector, which samples it only
// at second boundaries.
module rtc_cal_cfg_reg
    import rtc_cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CAL_CFG_W-1:0] wr_data,
    output logic [CAL_CFG_W-1:0] rd_data,
    output cal_cfg_t             cfg_live
);

    logic [CAL_CFG_W-1:0] cfg_q;

    // Hold the setting; cleared by reset, replaced on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    assign rd_data  = cfg_q;
    assign cfg_live = cal_cfg_t'(cfg_q);

endmodule

// File: rtl/rtc_cal_frac_accum.sv
`timescale 1ns/1ps
// Module rtc_cal_frac_accum
// Spreads OUT_PER_WIN output ticks over a window of win_len input ticks. Each
// input tick adds OUT_PER_WIN to a residue. When the sum reaches the window
// length, a tick fires and the length is subtracted. Across a whole window the
// residue returns to zero, and the last input tick of the window fires the
// last output tick. Assumes that win_len changes only when the residue is zero.
module rtc_cal_frac_accum #(
    parameter int IN_PER_WIN  = 512,
    parameter int OUT_PER_WIN = 100,
    parameter int WIN_W       = $clog2(IN_PER_WIN + 2),
    parameter int ACC_W       = $clog2(IN_PER_WIN + OUT_PER_WIN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [WIN_W-1:0] win_len,
    output logic             fire
);

    localparam logic [ACC_W-1:0] STEP = ACC_W'(OUT_PER_WIN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] win_ext;
    logic             reach;

    // Form the candidate sum and decide whether it reaches the window length.
    always_comb begin
        win_ext = ACC_W'(win_len);
        acc_sum = acc_q + STEP;
        reach   = (acc_sum >= win_ext);
        fire    = tick_in && reach;
    end

    // Update the residue on each input tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tick_in) begin
            acc_q <= reach ? (acc_sum - win_ext) : acc_sum;
        end
    end

endmodule

// File: rtl/rtc_cal_time_count.sv
`timescale 1ns/1ps
// Module rtc_cal_time_count
// Counts fired ticks into seconds and seconds into minutes, and keeps a minute
// parity bit. It registers the tick, second and minute strobes. It also
// reports, without a register, the second that will begin and that second's
// minute parity, so the window selector can load the next window at the edge
// that closes the current second.
module rtc_cal_time_count #(
    parameter int TICKS_PER_SEC = 100,
    parameter int SEC_PER_MIN   = 60,
    parameter int TICK_W        = $clog2(TICKS_PER_SEC),
    parameter int SEC_W         = $clog2(SEC_PER_MIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output logic             sec_wrap,
    output logic [SEC_W-1:0] next_sec,
    output logic             next_par,
    output logic             tick_q,
    output logic             sec_q,
    output logic             min_q
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_SEC - 1);
    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(SEC_PER_MIN - 1);

    logic [TICK_W-1:0] tick_cnt_q;
    logic [SEC_W-1:0]  sec_cnt_q;
    logic              par_q;
    logic              min_end;

    // Work out the second and parity that follow the current second.
    always_comb begin
        sec_wrap = fire && (tick_cnt_q == TICK_LAST);
        min_end  = (sec_cnt_q == SEC_LAST);
        next_sec = min_end ? '0 : sec_cnt_q + 1'b1;
        next_par = min_end ? ~par_q : par_q;
    end

    // Count ticks within the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (sec_wrap) begin
            tick_cnt_q <= '0;
        end else if (fire) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // Advance the second index and minute parity at each second boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_cnt_q <= '0;
            par_q     <= 1'b0;
        end else if (sec_wrap) begin
            sec_cnt_q <= next_sec;
            par_q     <= next_par;
        end
    end

    // Register the three strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            sec_q  <= 1'b0;
            min_q  <= 1'b0;
        end else begin
            tick_q <= fire;
            sec_q  <= sec_wrap;
            min_q  <= sec_wrap && min_end;
        end
    end

endmodule

// File: rtl/rtc_cal_window_sel.sv
`timescale 1ns/1ps
// Module rtc_cal_window_sel
// Chooses the window length for each second. At each second boundary it looks
// at the live setting, at the index of the second that is beginning and at
// that second's minute parity. It then loads IN_PER_WIN-1 (fast),
// IN_PER_WIN+1 (slow, even minutes only) or IN_PER_WIN. After reset the window
// is IN_PER_WIN. Assumes that load is high only at a second boundary.
module rtc_cal_window_sel
    import rtc_cal_pkg::*;
#(
    parameter int IN_PER_WIN = 512,
    parameter int SEC_W      = 6,
    parameter int WIN_W      = $clog2(IN_PER_WIN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  cal_cfg_t         cfg_live,
    input  logic [SEC_W-1:0] next_sec,
    input  logic             next_par,
    output logic [WIN_W-1:0] win_len
);

    localparam int CMP_W = ((SEC_W > CAL_MAG_W) ? SEC_W : CAL_MAG_W) + 1;
    localparam logic [WIN_W-1:0] WIN_PLAIN_LEN = WIN_W'(IN_PER_WIN);
    localparam logic [WIN_W-1:0] WIN_SHORT_LEN = WIN_W'(IN_PER_WIN - 1);
    localparam logic [WIN_W-1:0] WIN_LONG_LEN  = WIN_W'(IN_PER_WIN + 1);

    logic [CMP_W-1:0] sec_ext;
    logic [CMP_W-1:0] mag_ext;
    logic             in_span;
    win_kind_e        kind;
    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] win_q;

    // Decide whether the second that begins lies inside the corrected span.
    always_comb begin
        sec_ext = CMP_W'(next_sec);
        mag_ext = CMP_W'(cfg_live.mag);
        in_span = (cfg_live.mag != '0) && (sec_ext < mag_ext);
    end

    // Map direction and minute parity onto a window kind.
    always_comb begin
        if (!in_span) begin
            kind = WIN_PLAIN;
        end else if (cfg_live.fast) begin
            kind = WIN_SHORT;
        end else if (!next_par) begin
            kind = WIN_LONG;
        end else begin
            kind = WIN_PLAIN;
        end
    end

    // Translate the kind into a window length.
    always_comb begin
        unique case (kind)
            WIN_SHORT: win_d = WIN_SHORT_LEN;
            WIN_LONG:  win_d = WIN_LONG_LEN;
            default:   win_d = WIN_PLAIN_LEN;
        endcase
    end

    // Hold the window for the whole second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= WIN_PLAIN_LEN;
        end else if (load) begin
            win_q <= win_d;
        end
    end

    assign win_len = win_q;

endmodule

// File: rtl/rtc_cal_divider.sv
`timescale 1ns/1ps
// Module rtc_cal_divider (top)
// Divides a 512 Hz enable down to 100 Hz and trims the rate one second at a
// time through a 6-bit setting. It also produces second and minute strobes and
// an uncorrected test-frequency enable. Assumes that tick_in is high for at
// most one cycle at a time and that all inputs are synchronous to clk.
module rtc_cal_divider
    import rtc_cal_pkg::*;
#(
    parameter int IN_PER_WIN  = 512,
    parameter int OUT_PER_WIN = 100,
    parameter int SEC_PER_MIN = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_in,
    input  logic                 cfg_wr,
    input  logic [CAL_CFG_W-1:0] cfg_wdata,
    output logic [CAL_CFG_W-1:0] cfg_rdata,
    output logic                 tick_out,
    output logic                 sec_pulse,
    output logic                 min_pulse,
    output logic                 ftest_tick
);

    localparam int WIN_W  = $clog2(IN_PER_WIN + 2);
    localparam int ACC_W  = $clog2(IN_PER_WIN + OUT_PER_WIN + 2);
    localparam int SEC_W  = $clog2(SEC_PER_MIN);
    localparam int TICK_W = $clog2(OUT_PER_WIN);

    cal_cfg_t         cfg_live;
    logic [WIN_W-1:0] win_len;
    logic             fire;
    logic             sec_wrap;
    logic [SEC_W-1:0] next_sec;
    logic             next_par;
    logic             ftest_q;

    rtc_cal_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .cfg_live (cfg_live)
    );

    rtc_cal_frac_accum #(
        .IN_PER_WIN  (IN_PER_WIN),
        .OUT_PER_WIN (OUT_PER_WIN),
        .WIN_W       (WIN_W),
        .ACC_W       (ACC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_in),
        .win_len (win_len),
        .fire    (fire)
    );

    rtc_cal_time_count #(
        .TICKS_PER_SEC (OUT_PER_WIN),
        .SEC_PER_MIN   (SEC_PER_MIN),
        .TICK_W        (TICK_W),
        .SEC_W         (SEC_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .sec_wrap (sec_wrap),
        .next_sec (next_sec),
        .next_par (next_par),
        .tick_q   (tick_out),
        .sec_q    (sec_pulse),
        .min_q    (min_pulse)
    );

    rtc_cal_window_sel #(
        .IN_PER_WIN (IN_PER_WIN),
        .SEC_W      (SEC_W),
        .WIN_W      (WIN_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sec_wrap),
        .cfg_live (cfg_live),
        .next_sec (next_sec),
        .next_par (next_par),
        .win_len  (win_len)
    );

    // Register the uncorrected input enable for the test-frequency output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftest_q <= 1'b0;
        end else begin
            ftest_q <= tick_in;
        end
    end

    assign ftest_tick = ftest_q;

endmodule

// File: rtl/rtc_cal_divider_chk.sv
`timescale 1ns/1ps
// Module rtc_cal_divider_chk
// Checker bound to rtc_cal_divider. It watches the strobes, the read-back port,
// the test output and the internal window between boundaries. Assumes that
// tick_in is a single-cycle enable.
module rtc_cal_divider_chk #(
    parameter int OUT_PER_WIN = 100,
    parameter int WIN_W       = 10,
    parameter int CFG_W       = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             tick_out,
    input logic             sec_pulse,
    input logic             min_pulse,
    input logic             ftest_tick,
    input logic             sec_wrap,
    input logic [WIN_W-1:0] win_len
);

    localparam int CNT_W = $clog2(OUT_PER_WIN + 1);

    logic [CNT_W-1:0] ticks_seen;

    // Count output ticks since the last second strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_seen <= '0;
        end else if (sec_pulse) begin
            ticks_seen <= '0;
        end else if (tick_out) begin
            ticks_seen <= ticks_seen + 1'b1;
        end
    end

    // R1: an output tick only follows an input tick
    a_r1_tick_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> $past(tick_in));

    // R1: fewer than OUT_PER_WIN-1 ticks precede any tick that does not end a second
    a_r1_tick_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && !sec_pulse) |-> (ticks_seen < CNT_W'(OUT_PER_WIN - 1)));

    // R1: the second strobe falls on the last tick of the second
    a_r1_sec_on_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (tick_out && ticks_seen == CNT_W'(OUT_PER_WIN - 1)));

    // R6: a minute strobe always comes with a second strobe
    a_r6_min_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
        min_pulse |-> sec_pulse);

    // R7: read-back shows a written value in the following cycle
    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr)) |-> (cfg_rdata == $past(cfg_wdata)));

    // R8: the window only moves at a second boundary
    a_r8_window_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sec_wrap)) |-> $stable(win_len));

    // R9: the test output only follows an input tick
    a_r9_ftest_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        ftest_tick |-> $past(tick_in));

endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(
    .OUT_PER_WIN (OUT_PER_WIN),
    .WIN_W       (WIN_W),
    .CFG_W       (rtc_cal_pkg::CAL_CFG_W)
) u_rtc_cal_divider_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_in    (tick_in),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .tick_out   (tick_out),
    .sec_pulse  (sec_pulse),
    .min_pulse  (min_pulse),
    .ftest_tick (ftest_tick),
    .sec_wrap   (sec_wrap),
    .win_len    (win_len)
);

// File: tb/test_rtc_cal_divider.sv
`timescale 1ns/1ps
// Bench for rtc_cal_divider. The minute is shortened to SPM seconds. Each
// input tick is followed by one idle cycle. The length of every second is
// measured in input ticks and compared with a model of the requirements.
module test_rtc_cal_divider;

    localparam int SPM = 8;
    localparam int NVEC = 7;
    // {setting[5:0], seconds to run[5:0]}
    localparam logic [11:0] VEC [0:NVEC-1] = '{
        {6'b000000, 6'd3},
        {6'b100010, 6'd10},
        {6'b000011, 6'd20},
        {6'b100000, 6'd8},
        {6'b111111, 6'd9},
        {6'b011111, 6'd17},
        {6'b100111, 6'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_rdata;
    logic       tick_out, sec_pulse, min_pulse, ftest_tick;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    logic [5:0] cfg_now = '0;
    logic [5:0] cfg_cur = '0;
    int exp_win = 512;
    int b_sec = 0;
    bit b_par = 1'b0;
    int in_cnt = 0;
    int out_cnt = 0;
    int ft_cnt = 0;
    int sec_seen = 0;
    bit mid_write = 1'b0;
    bit after_reset = 1'b1;

    rtc_cal_divider #(.SEC_PER_MIN(SPM)) i_rtc_cal_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .tick_out   (tick_out),
        .sec_pulse  (sec_pulse),
        .min_pulse  (min_pulse),
        .ftest_tick (ftest_tick)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int win_for(input logic [5:0] c, input int s, input bit p);
        if (c[4:0] == 5'd0) return 512;
        if (s >= int'(c[4:0])) return 512;
        if (c[5]) return 511;
        if (!p) return 513;
        return 512;
    endfunction

    // One input tick plus one idle cycle, then sample the outputs.
    task automatic step();
        string tag;
        @(negedge clk);
        tick_in = 1'b1;
        in_cnt++;
        @(negedge clk);
        tick_in = 1'b0;
        if (ftest_tick) ft_cnt++;
        if (tick_out) out_cnt++;
        if (sec_pulse) begin
            if (mid_write) tag = "R8";
            else if (after_reset) tag = "R10";
            else if (exp_win == 511) tag = "R3";
            else if (exp_win == 513) tag = "R4";
            else if (cfg_cur[4:0] == 5'd0) tag = "R5";
            else tag = "R2";
            chk(in_cnt == exp_win, tag, in_cnt, exp_win);
            chk(out_cnt == 100, "R1", out_cnt, 100);
            chk(ft_cnt == in_cnt, "R9", ft_cnt, in_cnt);
            chk(min_pulse == (b_sec == SPM - 1), "R6", int'(min_pulse), int'(b_sec == SPM - 1));
            b_sec++;
            if (b_sec == SPM) begin
                b_sec = 0;
                b_par = ~b_par;
            end
            cfg_cur = cfg_now;
            exp_win = win_for(cfg_now, b_sec, b_par);
            in_cnt = 0;
            out_cnt = 0;
            ft_cnt = 0;
            mid_write = 1'b0;
            after_reset = 1'b0;
            sec_seen++;
        end else begin
            chk(!min_pulse, "R6", int'(min_pulse), 0);
        end
    endtask

    task automatic write_cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_rdata == v, "R7", int'(cfg_rdata), int'(v));
        cfg_now = v;
        mid_write = (cfg_now != cfg_cur);
    endtask

    task automatic run_seconds(input int n);
        int target;
        target = sec_seen + n;
        while (sec_seen < target) step();
    endtask

    task automatic check_reset_state();
        chk(!tick_out && !sec_pulse && !min_pulse && !ftest_tick, "R10",
            int'({tick_out, sec_pulse, min_pulse, ftest_tick}), 0);
        chk(cfg_rdata == 6'd0, "R7", int'(cfg_rdata), 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            repeat (137) step();
            write_cfg(VEC[i][11:6]);
            run_seconds(int'(VEC[i][5:0]));
        end

        // Reset in the middle of a second, with a correction active
        repeat (250) step();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        cfg_now = '0;
        cfg_cur = '0;
        exp_win = 512;
        b_sec = 0;
        b_par = 1'b0;
        in_cnt = 0;
        out_cnt = 0;
        ft_cnt = 0;
        mid_write = 1'b0;
        after_reset = 1'b1;
        // slow N=2 written at once: second 0 stays plain (R10), second 1 long (R4)
        write_cfg(6'b000010);
        mid_write = 1'b0;
        run_seconds(10);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule